// File: doc/BRIEF.md
# GPIO Interrupt Relay with Noise Filter

This block is the interrupt part of a general-purpose I/O controller. It takes up to 32 interrupt-capable pad signals and hands each one to a parent interrupt controller on a separate output wire. The interrupt-capable pads are GPIO lines 120 and upward, so interrupt n is pad 120+n. Nothing is latched here, and no two lines are ever combined. Pending state, acknowledge and priority all belong to the parent.

Each line has three control bits: an enable, a both-edge mode and a noise-filter enable. A single filter period register applies to all lines. Every pad is first resynchronised through two flops. It then passes through a per-line filter machine with two states:
- FLT_STEADY is the state while the sampled pad matches the accepted level. It moves to FLT_COUNT when the pad first differs. If the needed period is one cycle, it accepts the new level at once instead.
- FLT_COUNT counts consecutive differing samples. It goes back to FLT_STEADY in two cases: when the pad returns to the accepted level (the count is dropped), or when the count reaches the period (the new level is accepted).

A per-line pulse machine turns each accepted change into a one-cycle event:
- PLS_ARMED moves to PLS_FIRE when the filter reports an accepted change while filtering is on.
- PLS_FIRE returns to PLS_ARMED unless another accepted change arrives in the same cycle.

In level mode the output follows the accepted level, and the parent senses levels or single edges on it. In both-edge mode the output idles high and drops low while the pulse machine is in PLS_FIRE. The parent is set up to trigger on falling edges, so every pad transition reaches it as one falling edge.

Top module: `gpio_irq_relay`

## Requirements
- R1: After reset, the enable, mode and filter-enable registers read 0. The filter period register reads 0xFF. Every interrupt output is high.
- R2: The registers sit at byte addresses 0x90 (enable), 0x94 (mode), 0x98 (filter enable) and 0x9C (filter period). Bit n of the first three belongs to line n. Bits at or above the line count, and period bits at or above the period width, read 0. A write to any other address changes no register.
- R3: A line whose enable bit is 0 drives its output high whatever its pad does. Clearing the bit forces the output high right after the write edge.
- R4: With enable 1, mode 0 and filter 0, a line's output equals its own pad level. A pad change first shows on the third rising edge after it: two synchroniser flops, then the level register.
- R5: With the filter on and mode 0, a new level is taken only after P consecutive differing samples, where P is the period. The output changes on edge P+2 after the pad change. An excursion lasting fewer than P samples leaves the output unchanged. P = 0 behaves as P = 1.
- R6: With mode 1 and the filter on, each accepted pad change, rising or falling, drives the output low for exactly one cycle, on edge P+3 after the pad change. At all other times the output is high.
- R7: With mode 1 and the filter off, the output stays high; both-edge events exist only through the filter.
- R8: The one period value applies to every line. The filter enable is per line: in the same cycle, unfiltered lines see the R4 latency and filtered lines see the R5 latency.
- R9: Using the reset period (0xFF), a filtered change appears on the 257th edge after the pad change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, takes effect on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_i | input | NUM_LINES | Pad levels of the interrupt-capable lines |
| irq_o | output | NUM_LINES | Per-line unlatched outputs to the parent controller |

## Verification
Most internal faults show up at the outputs as timing errors, so the checks work at the cycle level:
- A filter counter that miscounts moves the output change off its exact edge (P+2 or P+3 after the pad change) by one cycle or more. It can also let a short glitch through, which changes the output within P+2 edges.
- A pulse machine stuck in PLS_FIRE holds the line low for a second cycle.
- A register that decodes the wrong address or bit shows up right away on read-back.
- Outputs tied together, or a mask that is ignored, show up on the first pad pattern where the lines differ.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int OFS_ENABLE = 'h90;
    localparam int OFS_MODE   = 'h94;
    localparam int OFS_FILTER = 'h98;
    localparam int OFS_PERIOD = 'h9C;
    localparam int PERIOD_RESET = 255;

    typedef enum logic {
        FLT_STEADY = 1'b0,
        FLT_COUNT  = 1'b1
    } flt_state_e;

    typedef enum logic {
        PLS_ARMED = 1'b0,
        PLS_FIRE  = 1'b1
    } pls_state_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8,
    parameter int PERIOD_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] en_o,
    output logic [NUM_LINES-1:0] mode_o,
    output logic [NUM_LINES-1:0] flt_o,
    output logic [PERIOD_W-1:0]  period_o
);
    logic hit_en, hit_mode, hit_flt, hit_per;

    always_comb begin
        hit_en   = (bus_addr == ADDR_W'(OFS_ENABLE));
        hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
        hit_flt  = (bus_addr == ADDR_W'(OFS_FILTER));
        hit_per  = (bus_addr == ADDR_W'(OFS_PERIOD));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o     <= '0;
            mode_o   <= '0;
            flt_o    <= '0;
            period_o <= PERIOD_W'(PERIOD_RESET);
        end else if (bus_wr) begin
            if (hit_en)   en_o     <= bus_wdata[NUM_LINES-1:0];
            if (hit_mode) mode_o   <= bus_wdata[NUM_LINES-1:0];
            if (hit_flt)  flt_o    <= bus_wdata[NUM_LINES-1:0];
            if (hit_per)  period_o <= bus_wdata[PERIOD_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_en)   bus_rdata[NUM_LINES-1:0] = en_o;
        if (hit_mode) bus_rdata[NUM_LINES-1:0] = mode_o;
        if (hit_flt)  bus_rdata[NUM_LINES-1:0] = flt_o;
        if (hit_per)  bus_rdata[PERIOD_W-1:0]  = period_o;
    end

    // R2: a write to the enable address lands in the enable register
    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_en) |=> (en_o == $past(bus_wdata[NUM_LINES-1:0])));
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter
    import gpio_irq_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                din,
    input  logic                flt_en,
    input  logic [PERIOD_W-1:0] period,
    output logic                level,
    output logic                flip
);
    localparam int CW = PERIOD_W + 1;

    flt_state_e          st_q, st_d;
    logic [PERIOD_W-1:0] cnt_q, cnt_d;
    logic                lvl_d, flip_d;
    logic [CW-1:0]       need, seen;

    always_comb begin
        need = (!flt_en || period == '0) ? CW'(1) : {1'b0, period};
        seen = {1'b0, cnt_q} + CW'(1);
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        lvl_d  = level;
        flip_d = 1'b0;
        unique case (st_q)
            FLT_STEADY: begin
                if (din != level) begin
                    if (need == CW'(1)) begin
                        lvl_d  = din;
                        flip_d = flt_en;
                    end else begin
                        st_d  = FLT_COUNT;
                        cnt_d = PERIOD_W'(1);
                    end
                end
            end
            FLT_COUNT: begin
                if (din == level) begin
                    st_d  = FLT_STEADY;
                    cnt_d = '0;
                end else if (seen >= need) begin
                    lvl_d  = din;
                    flip_d = flt_en;
                    st_d   = FLT_STEADY;
                    cnt_d  = '0;
                end else begin
                    cnt_d = cnt_q + PERIOD_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_STEADY;
            cnt_q <= '0;
            level <= 1'b1;
            flip  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            level <= lvl_d;
            flip  <= flip_d;
        end
    end

    // R5: with a period above one, a level is only taken from the counting state
    a_r5_wait_period: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_en && $past(flt_en) && $past(period) > PERIOD_W'(1) && level != $past(level))
        |-> ($past(st_q) == FLT_COUNT));
endmodule

// File: rtl/gpio_irq_pulse.sv
module gpio_irq_pulse
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic fire
);
    pls_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PLS_ARMED: if (flip) st_d = PLS_FIRE;
            PLS_FIRE:  st_d = flip ? PLS_FIRE : PLS_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PLS_ARMED;
        else        st_q <= st_d;
    end

    always_comb fire = (st_q == PLS_FIRE);

    // R6: a fire cycle is always caused by an accepted change one cycle earlier
    a_r6_fire_from_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PLS_FIRE) |-> $past(flip));
endmodule

// File: rtl/gpio_irq_relay.sv
module gpio_irq_relay
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8,
    parameter int PERIOD_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pad_i,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [NUM_LINES-1:0] en, mode, flt;
    logic [PERIOD_W-1:0]  period;
    logic [NUM_LINES-1:0] sync1, sync2, lvl, flip, fire;

    gpio_irq_regs #(
        .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en_o(en), .mode_o(mode), .flt_o(flt), .period_o(period)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= '1;
            sync2 <= '1;
        end else begin
            sync1 <= pad_i;
            sync2 <= sync1;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        gpio_irq_filter #(.PERIOD_W(PERIOD_W)) u_flt (
            .clk(clk), .rst_n(rst_n), .din(sync2[i]), .flt_en(flt[i]),
            .period(period), .level(lvl[i]), .flip(flip[i])
        );

        gpio_irq_pulse u_pls (
            .clk(clk), .rst_n(rst_n), .flip(flip[i]), .fire(fire[i])
        );

        assign irq_o[i] = !en[i]  ? 1'b1 :
                          mode[i] ? !(flt[i] && fire[i]) :
                                    lvl[i];

        // R4: an enabled level-mode line shows exactly its filtered level
        a_r4_level_path: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && !mode[i]) |-> (irq_o[i] == lvl[i]));
    end
endmodule

// File: tb/sim_gpio_irq_relay.sv
module sim_gpio_irq_relay;
    localparam int NL = 4;
    localparam logic [7:0] A_EN = 8'h90, A_MODE = 8'h94, A_FLT = 8'h98, A_PER = 8'h9C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = 8'h0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pad = '1;
    logic [NL-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    gpio_irq_relay #(.NUM_LINES(NL), .ADDR_W(8), .PERIOD_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_i(pad), .irq_o(irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=finished", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        logic [NL-1:0] prev;
        logic [NL-1:0] msk;
        int pe;

        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset values
        rd(A_EN, 32'h0, "R1 enable reset");
        rd(A_MODE, 32'h0, "R1 mode reset");
        rd(A_FLT, 32'h0, "R1 filter reset");
        rd(A_PER, 32'hFF, "R1 period reset");
        check("R1 outputs high", 32'(irq), 32'hF);

        // R9: default period 255 gives the change on edge 257
        wr(A_FLT, 32'hF);
        wr(A_EN, 32'hF);
        pad = 4'hD;
        step(256);
        check("R9 before edge 257", 32'(irq), 32'hF);
        step(1);
        check("R9 at edge 257", 32'(irq), 32'hD);
        pad = 4'hF;
        step(260);

        // R2: masking, width limits, unmapped writes
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, 32'hF, "R2 enable bits above lines");
        wr(A_PER, 32'h1234_5603);
        rd(A_PER, 32'h03, "R2 period width");
        wr(8'h00, 32'h5);
        wr(8'h91, 32'h0);
        rd(A_EN, 32'hF, "R2 unmapped write enable");
        rd(A_MODE, 32'h0, "R2 unmapped write mode");
        rd(A_PER, 32'h03, "R2 unmapped write period");
        rd(8'h40, 32'h0, "R2 unmapped read");

        // R4: exhaustive level sweep, no filter
        wr(A_FLT, 32'h0);
        step(4);
        prev = 4'hF;
        for (int v = 0; v < 16; v++) begin
            pad = NL'(v);
            step(2);
            check("R4 old level at edge 2", 32'(irq), 32'(prev));
            step(1);
            check("R4 new level at edge 3", 32'(irq), 32'(v));
            prev = NL'(v);
        end

        // R3: disabled lines high, enabled lines follow
        wr(A_EN, 32'h5);
        for (int v = 0; v < 16; v++) begin
            pad = NL'(v);
            step(3);
            check("R3 masked lines high", 32'(irq), 32'((NL'(v) & 4'h5) | 4'hA));
        end
        wr(A_EN, 32'hF);
        pad = 4'h0;
        step(4);
        check("R3 before disable", 32'(irq), 32'h0);
        wr(A_EN, 32'h0);
        check("R3 disable immediate", 32'(irq), 32'hF);
        wr(A_EN, 32'hF);
        pad = 4'hF;
        step(4);

        // R5: filtered level sweep across periods, plus short glitches
        wr(A_FLT, 32'hF);
        for (int k = 0; k < 5; k++) begin
            int p;
            p = (k == 0) ? 0 : (k == 4) ? 6 : k;
            pe = (p == 0) ? 1 : p;
            wr(A_PER, 32'(p));
            pad = 4'hF;
            step(pe + 4);
            pad = 4'hA;
            step(pe + 1);
            check("R5 old level at edge P+1", 32'(irq), 32'hF);
            step(1);
            check("R5 new level at edge P+2", 32'(irq), 32'hA);
            if (pe > 1) begin
                pad = 4'hF;
                step(pe - 1);
                pad = 4'hA;
                for (int c = 0; c < pe + 4; c++) begin
                    check("R5 glitch shorter than P ignored", 32'(irq), 32'hA);
                    step(1);
                end
            end
            pad = 4'hF;
            step(pe + 4);
        end

        // R8: shared period, per-line filter enable
        wr(A_FLT, 32'h3);
        wr(A_PER, 32'd5);
        step(8);
        pad = 4'h0;
        step(6);
        check("R8 unfiltered done, filtered pending", 32'(irq), 32'h3);
        step(1);
        check("R8 filtered lines at edge P+2", 32'(irq), 32'h0);
        pad = 4'hF;
        step(10);

        // R6: both-edge pulses on each line, each direction
        wr(A_FLT, 32'hF);
        wr(A_PER, 32'd3);
        wr(A_MODE, 32'hF);
        step(10);
        for (int l = 0; l < NL + 1; l++) begin
            msk = (l == NL) ? 4'h5 : NL'(1 << l);
            for (int d = 0; d < 2; d++) begin
                pad = pad ^ msk;
                for (int c = 1; c <= 8; c++) begin
                    step(1);
                    check("R6 single low cycle at edge P+3", 32'(irq),
                          32'((c == 6) ? (4'hF & ~msk) : 4'hF));
                end
            end
        end

        // R7: both-edge without filter stays high
        wr(A_FLT, 32'h0);
        for (int v = 0; v < 16; v++) begin
            pad = NL'(v);
            for (int c = 0; c < 3; c++) begin
                step(1);
                check("R7 no event without filter", 32'(irq), 32'hF);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule